// File: doc/BRIEF.md
# Serial Memory Write Guard

This block decides, byte by byte, whether a write into a 2048-byte memory array may proceed. It also decides whether a write to the array's status byte may proceed. It keeps three pieces of state:

- a write-enable latch, which software arms before each write command;
- a two-bit block-protect code, which fences off an upper slice of the array;
- a protect-enable bit, which hands control of the status byte to an active-low hardware write-protect pin.

A serial bus engine sits in front of the block. It presents pulses for arming and disarming the latch, a status-write pulse with its data byte, and a memory-write request with the 11-bit target address. For each request the engine gets a permit flag back in the same cycle. The status byte is always available for readback.

Software alone can reach a fully locked state. Setting the block-protect code to 11 and the protect-enable bit to 1, with the pin held low, refuses every array write and every status write. Only raising the pin undoes this.

Top module: `wprot_unit`

## Requirements
- R1: While reset is asserted, and right after reset, status_o reads 00h, and both permit outputs are 0 even when requests are presented.
- R2: While the write-enable latch is clear, mem_permit_o and sr_permit_o are 0 for every address, every pin level and every protection setting.
- R3: The block-protect code selects the refused address range as follows: 00 refuses none; 01 refuses 600h..7FFh; 10 refuses 400h..7FFh; 11 refuses 000h..7FFh. With the latch set, mem_permit_o is 1 exactly when mem_wr_i is 1 and the address lies outside the refused range.
- R4: A wel_set_i pulse sets the latch at the next clock edge. The latch is cleared at the next edge by wel_clr_i, or by any mem_wr_i or sr_wr_i cycle, whether or not that write was permitted. A clearing event takes priority over a simultaneous set.
- R5: A permitted status write loads the block-protect code from sr_data_i[3:2] and the protect-enable bit from sr_data_i[7]. Both are visible on status_o in the following cycle. sr_data_i[1] and the other data bits never change the latch or any stored bit.
- R6: With protect-enable 0 the pin has no effect, and a status write is permitted whenever the latch is set. With protect-enable 1, a status write is refused while the synchronized pin is 0 and permitted while it is 1. A refused status write leaves the block-protect and protect-enable bits unchanged.
- R7: The pin passes through SYNC_STAGES flops (default 2) that reset to 1. A pin change affects sr_permit_o after SYNC_STAGES rising clock edges.
- R8: The protect-enable bit and the pin never affect mem_permit_o.
- R9: status_o carries the latch in bit 1, the block-protect code in bits 3:2 and protect-enable in bit 7. Bits 0 and 6:4 read 0.
- R10: Both permit outputs are combinational from the current state and the request inputs, valid in the request cycle. Each is 0 when its request input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set_i | input | 1 | Pulse: arm the write-enable latch |
| wel_clr_i | input | 1 | Pulse: disarm the write-enable latch |
| sr_wr_i | input | 1 | Pulse: status write command |
| sr_data_i | input | 8 | Data byte for a status write |
| mem_wr_i | input | 1 | Memory byte write request |
| mem_addr_i | input | 11 | Target address of the byte write |
| wp_n_i | input | 1 | Hardware write-protect pin, active low, asynchronous |
| mem_permit_o | output | 1 | Memory byte write allowed this cycle |
| sr_permit_o | output | 1 | Status write allowed this cycle |
| status_o | output | 8 | Status byte for readback |

## Verification
The permit flags are due in the same cycle as their request. The bench therefore drives each cycle's inputs at the falling edge and compares the permits a few nanoseconds later, before the next rising edge. Latch, code and enable changes appear on status_o one edge after the command. Pin changes reach the status-write decision only after two edges. A bench model advances its own latch, code, enable and two-stage pin pipeline at each rising edge, and every prediction comes from that model's state in the cycle being checked.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
   localparam int unsigned SR_W       = 8;
   localparam int unsigned SR_WEL_BIT = 1;
   localparam int unsigned SR_BP_LSB  = 2;
   localparam int unsigned BP_W       = 2;
   localparam int unsigned SR_PE_BIT  = 7;

   typedef logic [BP_W-1:0] bp_code_t;

   localparam bp_code_t BP_NONE    = 2'b00;
   localparam bp_code_t BP_QUARTER = 2'b01;
   localparam bp_code_t BP_HALF    = 2'b10;
   localparam bp_code_t BP_ALL     = 2'b11;
endpackage

// File: rtl/wpu_pin_sync.sv
module wpu_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign pin_o = pin_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q <= pin_i;
            else chain_q <= {chain_q[STAGES-2+(STAGES==1):0], pin_i};
         end
         assign pin_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/wpu_region_dec.sv
module wpu_region_dec
   import wprot_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  bp_code_t          code_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              fenced_o
);
   localparam int unsigned DEPTH = 2 ** ADDR_W;
   localparam logic [ADDR_W-1:0] BOUND_QTR  = ADDR_W'(DEPTH - DEPTH / 4);
   localparam logic [ADDR_W-1:0] BOUND_HALF = ADDR_W'(DEPTH / 2);

   always_comb begin
      unique case (code_i)
         BP_NONE:    fenced_o = 1'b0;
         BP_QUARTER: fenced_o = (addr_i >= BOUND_QTR);
         BP_HALF:    fenced_o = (addr_i >= BOUND_HALF);
         default:    fenced_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/wpu_state.sv
module wpu_state
   import wprot_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_i,
   input  logic            clr_i,
   input  logic            mem_wr_i,
   input  logic            sr_wr_i,
   input  logic            sr_grant_i,
   input  logic [SR_W-1:0] sr_data_i,
   output logic            wel_o,
   output bp_code_t        bp_o,
   output logic            pe_o
);
   logic     wel_q;
   bp_code_t bp_q;
   logic     pe_q;
   logic     drop;

   assign drop = clr_i | mem_wr_i | sr_wr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
         bp_q  <= BP_NONE;
         pe_q  <= 1'b0;
      end else begin
         if (drop)       wel_q <= 1'b0;
         else if (set_i) wel_q <= 1'b1;
         if (sr_grant_i) begin
            bp_q <= sr_data_i[SR_BP_LSB +: BP_W];
            pe_q <= sr_data_i[SR_PE_BIT];
         end
      end
   end

   assign wel_o = wel_q;
   assign bp_o  = bp_q;
   assign pe_o  = pe_q;

   AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_i || sr_wr_i || clr_i) |=> !wel_q); // R4
   AST_WEL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !mem_wr_i && !sr_wr_i && !clr_i) |=> wel_q); // R4
   AST_REFUSED_SR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr_i && !sr_grant_i) |=> ($stable(bp_q) && $stable(pe_q))); // R6
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
   import wprot_pkg::*;
#(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              sr_wr_i,
   input  logic [SR_W-1:0]   sr_data_i,
   input  logic              mem_wr_i,
   input  logic [ADDR_W-1:0] mem_addr_i,
   input  logic              wp_n_i,
   output logic              mem_permit_o,
   output logic              sr_permit_o,
   output logic [SR_W-1:0]   status_o
);
   generate
      if (ADDR_W < 3 || ADDR_W > 24) begin : g_bad_addr
         $error("wprot_unit: ADDR_W out of range");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("wprot_unit: SYNC_STAGES above 4");
      end
      if (SR_PE_BIT >= SR_W || SR_BP_LSB + BP_W > SR_W) begin : g_bad_map
         $error("wprot_unit: status field outside byte");
      end
   endgenerate

   logic     wel;
   bp_code_t bp;
   logic     pe;
   logic     pin_s;
   logic     fenced;
   logic     sr_locked;

   wpu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(wp_n_i), .pin_o(pin_s));

   wpu_region_dec #(.ADDR_W(ADDR_W)) u_dec (
      .code_i(bp), .addr_i(mem_addr_i), .fenced_o(fenced));

   assign sr_locked    = pe & ~pin_s;
   assign mem_permit_o = mem_wr_i & wel & ~fenced;
   assign sr_permit_o  = sr_wr_i & wel & ~sr_locked;

   wpu_state u_state (
      .clk(clk), .rst_n(rst_n), .set_i(wel_set_i), .clr_i(wel_clr_i),
      .mem_wr_i(mem_wr_i), .sr_wr_i(sr_wr_i), .sr_grant_i(sr_permit_o),
      .sr_data_i(sr_data_i), .wel_o(wel), .bp_o(bp), .pe_o(pe));

   always_comb begin
      status_o = '0;
      status_o[SR_WEL_BIT] = wel;
      status_o[SR_BP_LSB +: BP_W] = bp;
      status_o[SR_PE_BIT] = pe;
   end

   AST_NO_PERMIT_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[SR_WEL_BIT] |-> (!mem_permit_o && !sr_permit_o)); // R2
   AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[SR_BP_LSB +: BP_W] == BP_ALL && status_o[SR_PE_BIT] && !pin_s)
      |-> (!mem_permit_o && !sr_permit_o)); // R6
   AST_SR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      sr_permit_o |=> (status_o[SR_BP_LSB +: BP_W] == $past(sr_data_i[SR_BP_LSB +: BP_W])
                       && status_o[SR_PE_BIT] == $past(sr_data_i[SR_PE_BIT]))); // R5
   AST_IDLE_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_i |-> !mem_permit_o) and (!sr_wr_i |-> !sr_permit_o)); // R10
endmodule

// File: tb/wprot_unit_tb_top.sv
module wprot_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wel_set_i = 0, wel_clr_i = 0, sr_wr_i = 0, mem_wr_i = 0;
   logic [7:0]  sr_data_i = 0;
   logic [10:0] mem_addr_i = 0;
   logic        wp_n_i = 1'b1;
   logic        mem_permit_o, sr_permit_o;
   logic [7:0]  status_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model state
   bit       m_wel;
   bit [1:0] m_bp;
   bit       m_pe;
   bit       m_s0, m_s1;

   always #10 clk = ~clk;

   wprot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
      .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .mem_wr_i(mem_wr_i),
      .mem_addr_i(mem_addr_i), .wp_n_i(wp_n_i), .mem_permit_o(mem_permit_o),
      .sr_permit_o(sr_permit_o), .status_o(status_o));

   function automatic bit fenced(bit [1:0] bp, bit [10:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a >= 11'h600;
         2'b10:   return a >= 11'h400;
         default: return 1'b1;
      endcase
   endfunction

   function automatic bit exp_mem();
      return mem_wr_i && m_wel && !fenced(m_bp, mem_addr_i);
   endfunction

   function automatic bit exp_sr();
      return sr_wr_i && m_wel && !(m_pe && !m_s1);
   endfunction

   function automatic bit [7:0] exp_status();
      return {m_pe, 3'b000, m_bp, m_wel, 1'b0};
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // one cycle: drive at negedge, check before posedge, advance model at posedge
   task automatic step(bit set, bit clr, bit srw, bit [7:0] d, bit mw, bit [10:0] a, bit pin);
      bit sr_ok;
      @(negedge clk);
      wel_set_i = set; wel_clr_i = clr; sr_wr_i = srw; sr_data_i = d;
      mem_wr_i = mw; mem_addr_i = a; wp_n_i = pin;
      #5;
      check("R3 R8 R10 mem_permit", mem_permit_o, exp_mem());
      check("R2 R6 R7 sr_permit", sr_permit_o, exp_sr());
      check("R4 R5 R9 status", status_o, exp_status());
      sr_ok = exp_sr();
      @(posedge clk);
      if (sr_ok) begin m_bp = d[3:2]; m_pe = d[7]; end
      if (clr || srw || mw) m_wel = 1'b0;
      else if (set) m_wel = 1'b1;
      m_s1 = m_s0; m_s0 = pin;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit pin;
      void'($urandom(32'h5EED_0042));
      m_wel = 0; m_bp = 0; m_pe = 0; m_s0 = 1; m_s1 = 1;
      // R1: requests during reset are refused, status reads zero
      repeat (3) @(negedge clk);
      wel_set_i = 1; sr_wr_i = 1; mem_wr_i = 1; sr_data_i = 8'hFF;
      #5;
      check("R1 reset mem_permit", mem_permit_o, 0);
      check("R1 reset sr_permit", sr_permit_o, 0);
      check("R1 reset status", status_o, 0);
      wel_set_i = 0; sr_wr_i = 0; mem_wr_i = 0;
      @(negedge clk); rst_n = 1;
      check("R1 after reset status", status_o, 0);

      // R2: disarmed latch refuses both kinds of write
      step(0,0,1,8'h0C,0,0,1);
      step(0,0,0,0,1,11'h000,1);
      // R5: permitted status write, code 01, data bit 1 ignored
      step(1,0,0,0,0,0,1);
      step(0,0,1,8'h06,0,0,1);
      step(0,0,0,0,0,0,1);
      // R3: boundaries for code 01
      step(1,0,0,0,0,0,1); step(0,0,0,0,1,11'h5FF,1);
      step(1,0,0,0,0,0,1); step(0,0,0,0,1,11'h600,1);
      // R4: clear beats simultaneous set
      step(1,1,0,0,0,0,1); step(0,0,0,0,0,0,1);
      // code 10 boundaries
      step(1,0,0,0,0,0,1); step(0,0,1,8'h08,0,0,1);
      step(1,0,0,0,0,0,1); step(0,0,0,0,1,11'h3FF,1);
      step(1,0,0,0,0,0,1); step(0,0,0,0,1,11'h400,1);
      // full lock: code 11, enable 1, pin low
      step(1,0,0,0,0,0,1); step(0,0,1,8'h8C,0,0,0);
      step(0,0,0,0,0,0,0); step(0,0,0,0,0,0,0);
      step(1,0,0,0,0,0,0); step(0,0,1,8'h00,0,0,0);
      step(1,0,0,0,1,11'h000,0); step(1,0,0,0,1,11'h7FF,0);
      // R7: pin rises; permitted only after two edges
      step(1,0,0,0,0,0,1); step(0,0,1,8'h00,0,0,1);
      step(1,0,0,0,0,0,1); step(1,0,0,0,0,0,1);
      step(0,0,1,8'h00,0,0,1); step(0,0,0,0,0,0,1);

      // constrained random mix
      pin = 1;
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 4) == 0) pin = ~pin;
         step($urandom_range(0, 9) < 5, $urandom_range(0, 9) == 0,
              $urandom_range(0, 9) < 2, 8'($urandom), $urandom_range(0, 9) < 4,
              11'($urandom), pin);
      end
      @(negedge clk);
      finish_run();
   end
endmodule